// File: doc/BRIEF.md
# Processor Trap Entry State Unit

This block performs the architectural control-state update that happens when a trap is taken on a processor with windowed registers. A one-cycle trap request carries the trap type. The unit samples the live control registers: trap level, processor state, hyper-state, condition codes, address space identifier, window pointer, can-save count, global level, PC and next PC. On the next clock edge it commits all the new values together. The committed values include the saved-state records written at the new trap level: a packed trap-state word, the saved PC and next PC, the saved hyper-state and the trap type.

The processor state receives a fixed set of per-bit edits. The global level steps up and saturates at a configured privileged ceiling. The window pointer moves by an amount chosen by the range the trap type falls in, and wraps within the number of register windows. Fetch is redirected: spill traps and fill traps each go to their own handler base input, and every other trap goes to a generic vector input. The next PC and the one after it follow the new PC at one-instruction and two-instruction offsets.

The surrounding pipeline presents the request. It takes the committed values from the outputs during the cycle in which the completion pulse is high. The output `newTl` also serves as the index for the saved-state writes.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset every output is zero and `done` is low.
- R2: A request sampled on a clock edge with `done` low commits all outputs at that edge, and `done` is high for exactly the following cycle.
- R3: A request present in the cycle where `done` is high is ignored: no output changes at the next edge, and `done` falls.
- R4: `newTl` is the incoming trap level plus one, taken modulo 8 for the 3-bit field (7 becomes 0).
- R5: `savedTstate` holds the global level in bits 42:40, the condition codes in bits 39:32, the address space identifier in bits 31:24, the incoming processor state in bits 20:8 and the incoming window pointer in bits 4:0. All other bits are zero.
- R6: `savedTpc`, `savedTnpc`, `savedHpstate` and `savedTt` hold the incoming PC, next PC, hyper-state and trap type.
- R7: `newPstate` is the incoming processor state with bit 4 set, bit 3 cleared, bit 2 set, bit 1 cleared and bit 9 replaced by incoming bit 8. Every other bit is unchanged.
- R8: `newGl` is the incoming global level plus one, limited to MAX_GL (default 2).
- R9: The window pointer changes according to the trap type. Type 0x024 adds 1. Types 0x080 to 0x0BF (spill) add can-save plus 2. Types 0x0C0 to 0x0FF (fill) subtract 1. Every other 9-bit type leaves it unchanged. Every adjusted value is taken modulo NWIN (default 8).
- R10: `newPc` is `spillBase` for spill types, `fillBase` for fill types and `vectorBase` otherwise. `newNpc` is `newPc`+4 and `newNnpc` is `newPc`+8.
- R11: With no request, all outputs hold their last committed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Trap request pulse |
| trapType | input | 9 | Trap type of the request |
| curTl | input | 3 | Current trap level |
| curGl | input | 3 | Current global level |
| curPstate | input | 13 | Current processor state |
| curHpstate | input | 12 | Current hyper-state |
| curCcr | input | 8 | Current condition codes |
| curAsi | input | 8 | Current address space identifier |
| curCwp | input | 5 | Current window pointer |
| curCansave | input | 5 | Current can-save count |
| curPc | input | 64 | Current PC |
| curNpc | input | 64 | Current next PC |
| spillBase | input | 64 | Spill handler start address |
| fillBase | input | 64 | Fill handler start address |
| vectorBase | input | 64 | Generic trap vector address |
| done | output | 1 | One-cycle commit pulse |
| newTl | output | 3 | New trap level, also the save index |
| newGl | output | 3 | New global level |
| newPstate | output | 13 | New processor state |
| newCwp | output | 5 | New window pointer |
| newPc | output | 64 | Redirected PC |
| newNpc | output | 64 | Redirected next PC |
| newNnpc | output | 64 | Redirected PC after next |
| savedTstate | output | 64 | Packed saved trap-state word |
| savedTpc | output | 64 | Saved PC |
| savedTnpc | output | 64 | Saved next PC |
| savedHpstate | output | 12 | Saved hyper-state |
| savedTt | output | 9 | Saved trap type |

## Verification
Two things can fall in the same cycle: the completion pulse of one trap and the arrival of another request. The bench holds the request high across two consecutive edges. It changes every control input and the trap class during the second cycle, so that a wrongly accepted request would show a different PC, window pointer and trap type. It judges the outcome one cycle later: the outputs must still show the first trap's results and the pulse must have fallen.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    WIN_KEEP   = 2'd0,
    WIN_PLUS1  = 2'd1,
    WIN_SPILL  = 2'd2,
    WIN_MINUS1 = 2'd3
  } winMove_e;

  typedef enum logic [1:0] {
    DEST_VECTOR = 2'd0,
    DEST_SPILL  = 2'd1,
    DEST_FILL   = 2'd2
  } dest_e;

  typedef struct packed {
    logic     commit;
    winMove_e winMove;
    dest_e    dest;
  } trapStrobe_t;

endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int TT_W = 9
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapReq,
  input  logic [TT_W-1:0] trapType,
  output trapStrobe_t     strobe,
  output logic            done
);

  localparam logic [TT_W-1:0] WINTRAP  = TT_W'(8'h24);
  localparam logic [TT_W-1:0] SPILL_LO = TT_W'(8'h80);
  localparam logic [TT_W-1:0] SPILL_HI = TT_W'(8'hBF);
  localparam logic [TT_W-1:0] FILL_LO  = TT_W'(8'hC0);
  localparam logic [TT_W-1:0] FILL_HI  = TT_W'(8'hFF);

  logic isSpill, isFill, isWinTrap;

  always_comb begin
    isSpill   = (trapType >= SPILL_LO) && (trapType <= SPILL_HI);
    isFill    = (trapType >= FILL_LO) && (trapType <= FILL_HI);
    isWinTrap = (trapType == WINTRAP);

    strobe.commit = trapReq && !done;
    if (isSpill) begin
      strobe.winMove = WIN_SPILL;
      strobe.dest    = DEST_SPILL;
    end else if (isFill) begin
      strobe.winMove = WIN_MINUS1;
      strobe.dest    = DEST_FILL;
    end else if (isWinTrap) begin
      strobe.winMove = WIN_PLUS1;
      strobe.dest    = DEST_VECTOR;
    end else begin
      strobe.winMove = WIN_KEEP;
      strobe.dest    = DEST_VECTOR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= strobe.commit;
  end

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !done) |=> done);

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int TT_W       = 9,
  parameter int TL_W       = 3,
  parameter int GL_W       = 3,
  parameter int MAX_GL     = 2,
  parameter int NWIN       = 8,
  parameter int CWP_W      = 5,
  parameter int PST_W      = 13,
  parameter int HPST_W     = 12,
  parameter int ADDR_W     = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobe_t       strobe,
  input  logic              done,
  input  logic [TT_W-1:0]   trapType,
  input  logic [TL_W-1:0]   curTl,
  input  logic [GL_W-1:0]   curGl,
  input  logic [PST_W-1:0]  curPstate,
  input  logic [HPST_W-1:0] curHpstate,
  input  logic [7:0]        curCcr,
  input  logic [7:0]        curAsi,
  input  logic [CWP_W-1:0]  curCwp,
  input  logic [CWP_W-1:0]  curCansave,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curNpc,
  input  logic [ADDR_W-1:0] spillBase,
  input  logic [ADDR_W-1:0] fillBase,
  input  logic [ADDR_W-1:0] vectorBase,
  output logic [TL_W-1:0]   newTl,
  output logic [GL_W-1:0]   newGl,
  output logic [PST_W-1:0]  newPstate,
  output logic [CWP_W-1:0]  newCwp,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newNpc,
  output logic [ADDR_W-1:0] newNnpc,
  output logic [63:0]       savedTstate,
  output logic [ADDR_W-1:0] savedTpc,
  output logic [ADDR_W-1:0] savedTnpc,
  output logic [HPST_W-1:0] savedHpstate,
  output logic [TT_W-1:0]   savedTt
);

  localparam int CWP_LSB = 0;
  localparam int PST_LSB = 8;
  localparam int ASI_LSB = 24;
  localparam int CCR_LSB = 32;
  localparam int GL_LSB  = 40;
  localparam int SUM_W   = CWP_W + 2;
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

  logic [TL_W-1:0]   tlNext;
  logic [GL_W:0]     glPlus;
  logic [GL_W-1:0]   glNext;
  logic [SUM_W-1:0]  winSum;
  logic [CWP_W-1:0]  cwpNext;
  logic [PST_W-1:0]  pstNext;
  logic [63:0]       tstateNext;
  logic [ADDR_W-1:0] destPc;

  always_comb begin
    tlNext = curTl + TL_W'(1);
    glPlus = {1'b0, curGl} + (GL_W+1)'(1);
    glNext = (glPlus > (GL_W+1)'(MAX_GL)) ? GL_W'(MAX_GL) : glPlus[GL_W-1:0];
  end

  always_comb begin
    unique case (strobe.winMove)
      WIN_PLUS1:  winSum = SUM_W'(curCwp) + SUM_W'(1);
      WIN_SPILL:  winSum = SUM_W'(curCwp) + SUM_W'(curCansave) + SUM_W'(2);
      WIN_MINUS1: winSum = SUM_W'(curCwp) + SUM_W'(NWIN - 1);
      default:    winSum = SUM_W'(curCwp);
    endcase
    if (strobe.winMove == WIN_KEEP) cwpNext = curCwp;
    else                            cwpNext = CWP_W'(winSum % SUM_W'(NWIN));
  end

  always_comb begin
    pstNext    = curPstate;
    pstNext[4] = 1'b1;
    pstNext[3] = 1'b0;
    pstNext[2] = 1'b1;
    pstNext[1] = 1'b0;
    pstNext[9] = curPstate[8];
  end

  always_comb begin
    tstateNext = '0;
    tstateNext[GL_LSB  +: GL_W]  = curGl;
    tstateNext[CCR_LSB +: 8]     = curCcr;
    tstateNext[ASI_LSB +: 8]     = curAsi;
    tstateNext[PST_LSB +: PST_W] = curPstate;
    tstateNext[CWP_LSB +: CWP_W] = curCwp;
  end

  always_comb begin
    unique case (strobe.dest)
      DEST_SPILL: destPc = spillBase;
      DEST_FILL:  destPc = fillBase;
      default:    destPc = vectorBase;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newTl        <= '0;
      newGl        <= '0;
      newPstate    <= '0;
      newCwp       <= '0;
      newPc        <= '0;
      newNpc       <= '0;
      newNnpc      <= '0;
      savedTstate  <= '0;
      savedTpc     <= '0;
      savedTnpc    <= '0;
      savedHpstate <= '0;
      savedTt      <= '0;
    end else if (strobe.commit) begin
      newTl        <= tlNext;
      newGl        <= glNext;
      newPstate    <= pstNext;
      newCwp       <= cwpNext;
      newPc        <= destPc;
      newNpc       <= destPc + STEP1;
      newNnpc      <= destPc + STEP2;
      savedTstate  <= tstateNext;
      savedTpc     <= curPc;
      savedTnpc    <= curNpc;
      savedHpstate <= curHpstate;
      savedTt      <= trapType;
    end
  end

  assert_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(newPc) && $stable(newCwp) && $stable(savedTt) && $stable(newTl)));

  assert_pstate_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (newPstate[4] && !newPstate[3] && newPstate[2] && !newPstate[1]));

  assert_gl_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (newGl <= GL_W'(MAX_GL)));

  assert_cwp_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (CWP_W'(newCwp) < CWP_W'(NWIN)));

  assert_npc_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((newNpc == newPc + STEP1) && (newNnpc == newPc + STEP2)));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int MAX_GL = 2,
  parameter int NWIN   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trapReq,
  input  logic [8:0]  trapType,
  input  logic [2:0]  curTl,
  input  logic [2:0]  curGl,
  input  logic [12:0] curPstate,
  input  logic [11:0] curHpstate,
  input  logic [7:0]  curCcr,
  input  logic [7:0]  curAsi,
  input  logic [4:0]  curCwp,
  input  logic [4:0]  curCansave,
  input  logic [63:0] curPc,
  input  logic [63:0] curNpc,
  input  logic [63:0] spillBase,
  input  logic [63:0] fillBase,
  input  logic [63:0] vectorBase,
  output logic        done,
  output logic [2:0]  newTl,
  output logic [2:0]  newGl,
  output logic [12:0] newPstate,
  output logic [4:0]  newCwp,
  output logic [63:0] newPc,
  output logic [63:0] newNpc,
  output logic [63:0] newNnpc,
  output logic [63:0] savedTstate,
  output logic [63:0] savedTpc,
  output logic [63:0] savedTnpc,
  output logic [11:0] savedHpstate,
  output logic [8:0]  savedTt
);

  trapStrobe_t strobe;

  trap_entry_ctrl #(.TT_W(9)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .trapReq  (trapReq),
    .trapType (trapType),
    .strobe   (strobe),
    .done     (done)
  );

  trap_entry_dp #(
    .TT_W(9), .TL_W(3), .GL_W(3), .MAX_GL(MAX_GL), .NWIN(NWIN),
    .CWP_W(5), .PST_W(13), .HPST_W(12), .ADDR_W(64), .INSN_BYTES(4)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .done         (done),
    .trapType     (trapType),
    .curTl        (curTl),
    .curGl        (curGl),
    .curPstate    (curPstate),
    .curHpstate   (curHpstate),
    .curCcr       (curCcr),
    .curAsi       (curAsi),
    .curCwp       (curCwp),
    .curCansave   (curCansave),
    .curPc        (curPc),
    .curNpc       (curNpc),
    .spillBase    (spillBase),
    .fillBase     (fillBase),
    .vectorBase   (vectorBase),
    .newTl        (newTl),
    .newGl        (newGl),
    .newPstate    (newPstate),
    .newCwp       (newCwp),
    .newPc        (newPc),
    .newNpc       (newNpc),
    .newNnpc      (newNnpc),
    .savedTstate  (savedTstate),
    .savedTpc     (savedTpc),
    .savedTnpc    (savedTnpc),
    .savedHpstate (savedHpstate),
    .savedTt      (savedTt)
  );

endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;

  typedef struct packed {
    logic [8:0] tt;
    logic [2:0] tl;
    logic [2:0] gl;
    logic [4:0] cwp;
    logic [4:0] cs;
    logic [4:0] expCwp;
    logic [1:0] expDest;   // 0 vector, 1 spill, 2 fill
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{9'h024, 3'd0, 3'd0, 5'd3, 5'd1, 5'd4, 2'd0},
    '{9'h024, 3'd7, 3'd1, 5'd7, 5'd0, 5'd0, 2'd0},
    '{9'h080, 3'd1, 3'd2, 5'd2, 5'd3, 5'd7, 2'd1},
    '{9'h0BF, 3'd2, 3'd3, 5'd6, 5'd4, 5'd4, 2'd1},
    '{9'h0C0, 3'd3, 3'd0, 5'd0, 5'd2, 5'd7, 2'd2},
    '{9'h0FF, 3'd4, 3'd1, 5'd5, 5'd0, 5'd4, 2'd2},
    '{9'h07F, 3'd5, 3'd2, 5'd5, 5'd6, 5'd5, 2'd0},
    '{9'h100, 3'd6, 3'd0, 5'd2, 5'd1, 5'd2, 2'd0},
    '{9'h1C0, 3'd1, 3'd1, 5'd1, 5'd3, 5'd1, 2'd0},
    '{9'h080, 3'd0, 3'd0, 5'd7, 5'd7, 5'd0, 2'd1}
  };

  localparam logic [63:0] SPILL_B = 64'h0000_4000_0000_0800;
  localparam logic [63:0] FILL_B  = 64'h0000_4000_0000_0C00;
  localparam logic [63:0] VEC_B   = 64'h0000_4000_0000_0400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapReq = 1'b0;
  logic [8:0]  trapType = '0;
  logic [2:0]  curTl = '0, curGl = '0;
  logic [12:0] curPstate = '0;
  logic [11:0] curHpstate = '0;
  logic [7:0]  curCcr = '0, curAsi = '0;
  logic [4:0]  curCwp = '0, curCansave = '0;
  logic [63:0] curPc = '0, curNpc = '0;
  logic        done;
  logic [2:0]  newTl, newGl;
  logic [12:0] newPstate;
  logic [4:0]  newCwp;
  logic [63:0] newPc, newNpc, newNnpc, savedTstate, savedTpc, savedTnpc;
  logic [11:0] savedHpstate;
  logic [8:0]  savedTt;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  trap_entry_unit uut (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .curTl(curTl), .curGl(curGl), .curPstate(curPstate), .curHpstate(curHpstate),
    .curCcr(curCcr), .curAsi(curAsi), .curCwp(curCwp), .curCansave(curCansave),
    .curPc(curPc), .curNpc(curNpc), .spillBase(SPILL_B), .fillBase(FILL_B),
    .vectorBase(VEC_B), .done(done), .newTl(newTl), .newGl(newGl),
    .newPstate(newPstate), .newCwp(newCwp), .newPc(newPc), .newNpc(newNpc),
    .newNnpc(newNnpc), .savedTstate(savedTstate), .savedTpc(savedTpc),
    .savedTnpc(savedTnpc), .savedHpstate(savedHpstate), .savedTt(savedTt)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [12:0] expPst(input logic [12:0] p);
    logic [12:0] r;
    r = p;
    r[4] = 1'b1; r[3] = 1'b0; r[2] = 1'b1; r[1] = 1'b0; r[9] = p[8];
    return r;
  endfunction

  function automatic logic [2:0] expGl(input logic [2:0] g);
    return (g >= 3'd2) ? 3'd2 : g + 3'd1;
  endfunction

  function automatic logic [63:0] expTs(input logic [2:0] g, input logic [7:0] c,
      input logic [7:0] a, input logic [12:0] p, input logic [4:0] w);
    return ({61'd0, g} << 40) | ({56'd0, c} << 32) | ({56'd0, a} << 24) |
           ({51'd0, p} << 8) | {59'd0, w};
  endfunction

  task automatic drive(input int i);
    trapType   = VECS[i].tt;
    curTl      = VECS[i].tl;
    curGl      = VECS[i].gl;
    curCwp     = VECS[i].cwp;
    curCansave = VECS[i].cs;
    curPstate  = 13'h0155 + 13'(i * 13'h0317);
    curHpstate = 12'hA50 ^ 12'(i);
    curCcr     = 8'(8'h11 * i + 3);
    curAsi     = 8'h80 | 8'(i);
    curPc      = 64'h1000_0000 + 64'(i * 64);
    curNpc     = curPc + 64'd4;
  endtask

  task automatic checkCommit(input int i);
    logic [63:0] base;
    base = (VECS[i].expDest == 2'd1) ? SPILL_B : (VECS[i].expDest == 2'd2) ? FILL_B : VEC_B;
    chk($sformatf("R2 done v%0d", i), {63'd0, done}, 64'd1);
    chk($sformatf("R4 tl v%0d", i), {61'd0, newTl}, {61'd0, 3'(VECS[i].tl + 3'd1)});
    chk($sformatf("R5 tstate v%0d", i), savedTstate,
        expTs(curGl, curCcr, curAsi, curPstate, curCwp));
    chk($sformatf("R6 tpc v%0d", i), savedTpc, curPc);
    chk($sformatf("R6 tnpc v%0d", i), savedTnpc, curNpc);
    chk($sformatf("R6 hpstate v%0d", i), {52'd0, savedHpstate}, {52'd0, curHpstate});
    chk($sformatf("R6 tt v%0d", i), {55'd0, savedTt}, {55'd0, VECS[i].tt});
    chk($sformatf("R7 pstate v%0d", i), {51'd0, newPstate}, {51'd0, expPst(curPstate)});
    chk($sformatf("R8 gl v%0d", i), {61'd0, newGl}, {61'd0, expGl(VECS[i].gl)});
    chk($sformatf("R9 cwp v%0d", i), {59'd0, newCwp}, {59'd0, VECS[i].expCwp});
    chk($sformatf("R10 pc v%0d", i), newPc, base);
    chk($sformatf("R10 npc v%0d", i), newNpc, base + 64'd4);
    chk($sformatf("R10 nnpc v%0d", i), newNnpc, base + 64'd8);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] holdPc;
    logic [4:0]  holdCwp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 pc", newPc, 64'd0);
    chk("R1 tstate", savedTstate, 64'd0);
    chk("R1 cwp/tl/gl", {53'd0, newCwp, newTl, newGl}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(i);
      trapReq = 1'b1;
      @(negedge clk);
      trapReq = 1'b0;
      checkCommit(i);
      holdPc  = newPc;
      holdCwp = newCwp;
      @(negedge clk);
      // R11 hold with no request
      chk($sformatf("R11 done low v%0d", i), {63'd0, done}, 64'd0);
      chk($sformatf("R11 pc hold v%0d", i), newPc, holdPc);
      chk($sformatf("R11 cwp hold v%0d", i), {59'd0, newCwp}, {59'd0, holdCwp});
    end

    // R3: request during the done cycle is ignored
    drive(2);
    trapReq = 1'b1;
    @(negedge clk);
    checkCommit(2);
    drive(4);
    trapReq = 1'b1;
    @(negedge clk);
    trapReq = 1'b0;
    chk("R3 done falls", {63'd0, done}, 64'd0);
    chk("R3 pc unchanged", newPc, SPILL_B);
    chk("R3 cwp unchanged", {59'd0, newCwp}, {59'd0, VECS[2].expCwp});
    chk("R3 tt unchanged", {55'd0, savedTt}, {55'd0, VECS[2].tt});
    chk("R3 tl unchanged", {61'd0, newTl}, {61'd0, 3'(VECS[2].tl + 3'd1)});
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule